// File: doc/BRIEF.md
# Signed-Amount Barrel Shifter

This block is a 32-bit datapath shifter driven by a single signed shift amount. One input word, a two-bit operation kind and a six-bit two's-complement amount produce one result word. A non-negative amount moves bits toward the least significant end. A negative amount moves them toward the most significant end by the amount's magnitude. One amount port therefore covers both directions for every operation kind.

The shifting itself is a logarithmic mux network. Five conditional stages move the word right by 1, 2, 4, 8 and 16 positions. Left moves reuse the same network by reversing the bit order of the word before the stages and again after them. The operation kind picks zero fill, sign fill or wrap-around. The result is captured in an output register with a synchronous active-high reset. A parameter can remove that register and leave a purely combinational path.

Top module: `bsh_core`

## Requirements
- R1: With the default output register, `dout` shows the result for the inputs sampled at a rising clock edge from that edge until the next one. While `rst` is high at a rising edge, `dout` becomes 0.
- R2: `amt` is two's complement. A value from 0 to 31 shifts toward bit 0 by that many places. A value from -1 to -32 (bit 5 set) shifts toward bit 31 by its magnitude.
- R3: With kind 2'b00 (logical) and a non-negative amount, the vacated high bits are zero. For example, 0x87654321 with amount 0x10 gives 0x00008765.
- R4: With kind 2'b01 (arithmetic) and a non-negative amount, the vacated high bits copy input bit 31. For example, 0x87654321 with amount 0x14 gives 0xFFFFF876.
- R5: With a negative amount, kinds 2'b00 and 2'b01 both shift toward bit 31 and fill the vacated low bits with zero.
- R6: With kind 2'b10 (rotate), bits leaving one end re-enter at the other and the number of set bits is kept. For example, 0x87654321 with amount 0x30 (-16) gives 0x43218765.
- R7: An amount of 0 returns the input unchanged for every kind.
- R8: An amount of -32 (0x20) gives 0 for kinds 2'b00 and 2'b01, and the unchanged input for kind 2'b10.
- R9: Kind 2'b11 returns the input unchanged for every amount.
- R10: For kinds 00, 01 and 10, every one of the 64 amount codes gives the value defined by R2 to R8 on arbitrary data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1  | Clock for the output register |
| rst  | input  | 1  | Synchronous active-high reset, clears `dout` |
| din  | input  | 32 | Word to be shifted |
| kind | input  | 2  | 00 logical, 01 arithmetic, 10 rotate, 11 pass-through |
| amt  | input  | 6  | Signed shift amount: non-negative shifts right, negative shifts left |
| dout | output | 32 | Shifted word, registered |

## Verification
The word 0x87654321 has distinct nibbles and its top bit set. With it, a wrong stage, a wrong fill source or a wrong direction shows up as a recognisable misplaced digit. The same shifts on a word with bit 31 clear separate sign fill from one-fill. The amounts 0, 31, -1 and -32 test the edges of the signed range, where the magnitude needs the sixth bit and rotate must wrap to identity. A sweep of all 64 amounts over each kind on random words checks every stage combination in both directions against a behavioural model.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [1:0] {
    SH_LOG  = 2'b00,
    SH_ARI  = 2'b01,
    SH_ROT  = 2'b10,
    SH_PASS = 2'b11
  } sh_kind_e;
endpackage

// File: rtl/bsh_bitrev.sv
module bsh_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign y[i] = a[W-1-i];
  end
endmodule

// File: rtl/bsh_rnet.sv
// Logarithmic right-moving network: stage s moves by 2**s when n[s] is set.
module bsh_rnet #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] n,
  input  logic          wrap,
  input  logic          fill,
  output logic [W-1:0]  q
);
  logic [SW:0][W-1:0] lvl;

  assign lvl[0] = d;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int K = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i + K < W) begin : g_in
        assign lvl[s+1][i] = n[s] ? lvl[s][i+K] : lvl[s][i];
      end else begin : g_edge
        assign lvl[s+1][i] = n[s] ? (wrap ? lvl[s][i+K-W] : fill) : lvl[s][i];
      end
    end
  end

  assign q = lvl[SW];
endmodule

// File: rtl/bsh_core.sv
module bsh_core #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [W-1:0]           din,
  input  logic [1:0]             kind,
  input  logic [$clog2(W):0]     amt,
  output logic [W-1:0]           dout
);
  import bsh_pkg::*;

  localparam int SW = $clog2(W);
  localparam int AW = SW + 1;

  sh_kind_e          k;
  logic              neg;
  logic [AW-1:0]     mag;
  logic              full;
  logic              wrap;
  logic              fill;
  logic [W-1:0]      din_rev;
  logic [W-1:0]      net_in;
  logic [W-1:0]      net_out;
  logic [W-1:0]      out_rev;
  logic [W-1:0]      moved;
  logic [W-1:0]      res;

  assign k    = sh_kind_e'(kind);
  assign neg  = amt[AW-1];
  assign mag  = neg ? (~amt + 1'b1) : amt;
  // Magnitude equal to W only arises for the most negative code.
  assign full = mag[SW];
  assign wrap = (k == SH_ROT);
  assign fill = (k == SH_ARI) && !neg && din[W-1];

  bsh_bitrev #(.W(W)) u_rev_in  (.a(din),     .y(din_rev));

  assign net_in = neg ? din_rev : din;

  bsh_rnet #(.W(W), .SW(SW)) u_net (
    .d    (net_in),
    .n    (mag[SW-1:0]),
    .wrap (wrap),
    .fill (fill),
    .q    (net_out)
  );

  bsh_bitrev #(.W(W)) u_rev_out (.a(net_out), .y(out_rev));

  assign moved = neg ? out_rev : net_out;

  always_comb begin
    if (k == SH_PASS)      res = din;
    else if (full && !wrap) res = '0;
    else                   res = moved;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) dout <= '0;
      else     dout <= res;
    end
  end else begin : g_comb
    assign dout = res;
  end
endmodule

// File: rtl/bsh_core_chk.sv
module bsh_core_chk #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         din,
  input logic [1:0]           kind,
  input logic [$clog2(W):0]   amt,
  input logic [W-1:0]         dout
);
  localparam int AW = $clog2(W) + 1;
  localparam logic [AW-1:0] MOST_NEG = {1'b1, {(AW-1){1'b0}}};

  if (REG_OUT) begin : g_chk
    // R1
    reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> dout == '0);
    // R9
    pass_kind_chk: assert property (@(posedge clk) disable iff (rst)
      kind == 2'b11 |=> dout == $past(din));
    // R7
    zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
      amt == '0 |=> dout == $past(din));
    // R6
    rot_ones_chk: assert property (@(posedge clk) disable iff (rst)
      kind == 2'b10 |=> $countones(dout) == $countones($past(din)));
    // R3
    log_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == 2'b00 && !amt[AW-1] && amt != '0) |=> !dout[W-1]);
    // R4
    ari_sign_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == 2'b01 && !amt[AW-1]) |=> dout[W-1] == $past(din[W-1]));
    // R5
    left_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (kind[1] == 1'b0 && amt[AW-1]) |=> !dout[0]);
    // R8
    full_left_chk: assert property (@(posedge clk) disable iff (rst)
      (kind[1] == 1'b0 && amt == MOST_NEG) |=> dout == '0);
  end
endmodule

bind bsh_core bsh_core_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .kind (kind),
  .amt  (amt),
  .dout (dout)
);

// File: tb/bsh_core_tb.sv
`timescale 1ns/1ps
module bsh_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic [1:0]  kind = 2'b00;
  logic [5:0]  amt = '0;
  logic [31:0] dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bsh_core u_dut (.clk(clk), .rst(rst), .din(din), .kind(kind), .amt(amt), .dout(dout));

  function automatic logic [31:0] model(input logic [31:0] d, input logic [1:0] k,
                                        input logic [5:0] a);
    int s;
    int m;
    logic [63:0] dd;
    s  = $signed(a);
    dd = {d, d};
    if (k == 2'b11) return d;
    if (s >= 0) begin
      m = s;
      case (k)
        2'b00:   return d >> m;
        2'b01:   return 32'($signed(d) >>> m);
        default: return 32'(dd >> m);
      endcase
    end else begin
      m = -s;
      if (k == 2'b10) begin
        dd = dd << (m % 32);
        return dd[63:32];
      end
      if (m >= 32) return '0;
      return d << m;
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (din=%h kind=%b amt=%h)", req, act, exp, din, kind, amt);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [1:0] k, input logic [5:0] a);
    @(negedge clk);
    din = d; kind = k; amt = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    din = 32'hFFFF_FFFF; kind = 2'b11; amt = '0;
    @(negedge clk); @(negedge clk);
    check("R1 reset", dout, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 latency", dout, 32'hFFFF_FFFF);
  endtask

  task automatic t_examples();
    apply(32'h8765_4321, 2'b00, 6'h10); check("R3 logical right 16", dout, 32'h0000_8765);
    apply(32'h8765_4321, 2'b01, 6'h14); check("R4 arith right 20", dout, 32'hFFFF_F876);
    apply(32'h7765_4321, 2'b01, 6'h14); check("R4 arith positive", dout, 32'h0000_0776);
    apply(32'h8765_4321, 2'b10, 6'h30); check("R6 rotate -16", dout, 32'h4321_8765);
    apply(32'h8765_4321, 2'b10, 6'h04); check("R6 rotate right 4", dout, 32'h1876_5432);
    apply(32'h8765_4321, 2'b00, 6'h01); check("R2 right 1", dout, 32'h43B2_A190);
    apply(32'h8765_4321, 2'b00, 6'h3F); check("R2 left 1", dout, 32'h0ECA_8642);
  endtask

  task automatic t_left_fill();
    apply(32'h8765_4321, 2'b01, 6'h38); check("R5 arith left 8", dout, 32'h6543_2100);
    apply(32'hFFFF_FFFF, 2'b00, 6'h21); check("R5 logical left 31", dout, 32'h8000_0000);
  endtask

  task automatic t_edges();
    for (int k = 0; k < 3; k++) begin
      apply(32'hA5C3_0F96, 2'(k), 6'h00); check("R7 zero amount", dout, 32'hA5C3_0F96);
    end
    apply(32'hDEAD_BEEF, 2'b00, 6'h20); check("R8 logical -32", dout, 32'h0);
    apply(32'hDEAD_BEEF, 2'b01, 6'h20); check("R8 arith -32", dout, 32'h0);
    apply(32'hDEAD_BEEF, 2'b10, 6'h20); check("R8 rotate -32", dout, 32'hDEAD_BEEF);
    apply(32'h8000_0000, 2'b01, 6'h1F); check("R4 arith right 31", dout, 32'hFFFF_FFFF);
    apply(32'h8000_0000, 2'b00, 6'h1F); check("R3 logical right 31", dout, 32'h0000_0001);
  endtask

  task automatic t_pass();
    apply(32'h1357_9BDF, 2'b11, 6'h10); check("R9 pass +16", dout, 32'h1357_9BDF);
    apply(32'h1357_9BDF, 2'b11, 6'h20); check("R9 pass -32", dout, 32'h1357_9BDF);
    apply(32'h1357_9BDF, 2'b11, 6'h3F); check("R9 pass -1", dout, 32'h1357_9BDF);
  endtask

  task automatic t_sweep();
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < 3; k++) begin
        for (int a = 0; a < 64; a++) begin
          logic [31:0] d;
          d = $urandom();
          apply(d, 2'(k), 6'(a));
          check("R10 sweep", dout, model(d, 2'(k), 6'(a)));
        end
      end
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_examples();
    t_left_fill();
    t_edges();
    t_pass();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule